// File: doc/BRIEF.md
# UART FIFO Register Interface

This block is the host-facing register file of one serial channel in a 16550-class UART. It holds the receive and transmit FIFOs and the FIFO control word. It also decodes an 8-bit host bus with a 3-bit address and separate read and write strobes. A bank-select bit in the line control register switches the low three addresses between the data, interrupt-enable and interrupt-identification/FIFO-control registers and the divisor and alternate-function registers.

The receive shifter pushes bytes in through `rx_push`, each with an error tag. The transmit shifter pulls bytes out through `tx_pop`. The host enables, disables and flushes the FIFOs and picks the receive trigger level. It also chooses how the two ready outputs signal to a DMA engine. When the FIFOs are disabled, each direction holds a single byte, as a holding register does.

Top module: `uart_fifo_regif`

## Requirements
- R1: After reset, the FIFOs are off and both are empty. The line control, interrupt-enable and divisor registers read 0. A read at address 2 returns 0x01, a read at address 5 returns 0x20, `rx_ready` is 0 and `tx_ready` is 1.
- R2: Address 2 is shared when bank-select (LCR bit 7) is 0. A read returns the interrupt identification byte and a write loads the FIFO control word. The identification byte has bits 7:6 = 11 while the FIFOs are on and 00 otherwise. Its bits 3:0 are 0100 when receive data is available with IER bit 0 set, else 0010 when the transmit FIFO is empty with IER bit 1 set, else 0001. `irq` is high when bits 3:0 are not 0001.
- R3: With LCR bit 7 = 1, addresses 0, 1 and 2 read and write the divisor low byte, the divisor high byte and the alternate function byte. With it 0, address 0 pops receive and pushes transmit data, and address 1 is the 4-bit interrupt-enable register. Address 3 is the line control register.
- R4: A control write with bit 0 = 0 has no effect through bits 1 to 7. No flush happens unless the enable bit changes, and the trigger and mode fields keep their values.
- R5: A control write that changes bit 0 empties both FIFOs.
- R6: A control write with bits 0 and 1 set empties only the receive FIFO. A control write with bits 0 and 2 set empties only the transmit FIFO. The flush bits are never stored.
- R7: Each FIFO holds 16 bytes when on and 1 byte when off. A receive push into a full FIFO is dropped and sets the overrun flag, which is LSR bit 1. A read of address 5 clears that flag. A transmit push into a full FIFO is dropped. Bytes leave each FIFO in arrival order.
- R8: A pop from an empty FIFO returns the last byte popped from it, or 0 if none has been popped, and the count stays 0.
- R9: Trigger field (control bits 7:6) codes 00, 01, 10 and 11 select 1, 4, 8 and 14 bytes. While the FIFOs are on, receive data is available when the count is at or above that level. While they are off, it is available when one byte is held.
- R10: Mode 1 holds when the FIFOs are on and control bit 3 is set. In mode 1, `rx_ready` follows receive-data-available and `tx_ready` is high while the transmit FIFO is not full. In mode 0, `rx_ready` is high while the receive FIFO is not empty and `tx_ready` is high while the transmit FIFO is empty.
- R11: LSR (address 5) has bit 0 set while the receive FIFO holds data and bit 5 set while the transmit FIFO is empty. Bit 7 is set while the FIFOs are on and at least one held receive byte carries an error tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Host register address |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe (causes pop / flag clear) |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data for the addressed register |
| rx_push | input | 1 | Receive shifter delivers a byte |
| rx_byte | input | 8 | Received byte |
| rx_err | input | 1 | Error tag for the received byte |
| tx_pop | input | 1 | Transmit shifter takes a byte |
| tx_byte | output | 8 | Byte at the transmit FIFO head |
| tx_has_data | output | 1 | Transmit FIFO not empty |
| rx_ready | output | 1 | Receive DMA ready |
| tx_ready | output | 1 | Transmit DMA ready |
| irq | output | 1 | Interrupt request |
| fifos_on | output | 1 | FIFO enable state |
| line_ctrl | output | 7 | Line format bits for the shifters |
| divisor | output | 16 | Baud divisor |
| alt_func | output | 8 | Alternate function byte |

## Verification
The checker enforces several properties on every cycle: the FIFO capacity limit in both enable states, and the flush that follows a change of the enable bit or a set flush bit. It also checks that a disabling-state write leaves the trigger and mode fields untouched, that overrun is raised by a push into a full receive FIFO, that the mode-0 receive ready follows the count, and that the identification byte carries the enabled marker. The bench shows the rest through scenarios: byte order through a full FIFO, last-value return on an empty pop, the flag clearing on a status read, and the error-summary bit. It also sweeps every trigger code against every fill level from 0 to 16 to check the ready and identification outputs.

// File: rtl/uart_fr_pkg.sv
package uart_fr_pkg;

  localparam logic [2:0] A_DATA = 3'd0;
  localparam logic [2:0] A_IER  = 3'd1;
  localparam logic [2:0] A_IDFC = 3'd2;
  localparam logic [2:0] A_LCR  = 3'd3;
  localparam logic [2:0] A_LSR  = 3'd5;

  typedef struct packed {
    logic [1:0] trig;
    logic       dma;
    logic       on;
  } fcr_t;

endpackage

// File: rtl/urt_byte_fifo.sv
module urt_byte_fifo #(
  parameter int W = 8,
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          single,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          push_ok,
  output logic          pop_ok
);
  localparam int PW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr, rd_ptr_nx, wr_ptr_nx;
  logic [CW-1:0] count_nx, cap;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign cap     = single ? CW'(1) : CW'(DEPTH);
  assign full    = (count >= cap);
  assign push_ok = push & ~full & ~flush;
  assign pop_ok  = pop & (count != '0) & ~flush;
  assign head    = mem[rd_ptr];

  always_comb begin
    wr_ptr_nx = wr_ptr;
    rd_ptr_nx = rd_ptr;
    count_nx  = count;
    if (flush) begin
      wr_ptr_nx = '0;
      rd_ptr_nx = '0;
      count_nx  = '0;
    end else begin
      if (push_ok) wr_ptr_nx = bump(wr_ptr);
      if (pop_ok)  rd_ptr_nx = bump(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count_nx = count + 1'b1;
        2'b01:   count_nx = count - 1'b1;
        default: count_nx = count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_nx;
      rd_ptr <= rd_ptr_nx;
      count  <= count_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

endmodule

// File: rtl/urt_fcr_ctl.sv
module urt_fcr_ctl
  import uart_fr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fcr_wr,
  input  logic [7:0] wdata,
  output fcr_t       fcr,
  output logic       rx_flush,
  output logic       tx_flush
);
  fcr_t fcr_nx;
  logic en_change;
  logic unused_rsvd;

  assign unused_rsvd = ^wdata[5:4];
  assign en_change   = fcr_wr & (wdata[0] != fcr.on);
  assign rx_flush    = en_change | (fcr_wr & wdata[0] & wdata[1]);
  assign tx_flush    = en_change | (fcr_wr & wdata[0] & wdata[2]);

  always_comb begin
    fcr_nx = fcr;
    if (fcr_wr) begin
      fcr_nx.on = wdata[0];
      if (wdata[0]) begin
        fcr_nx.dma  = wdata[3];
        fcr_nx.trig = wdata[7:6];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fcr <= '0;
    else        fcr <= fcr_nx;
  end

endmodule

// File: rtl/uart_fifo_regif.sv
module uart_fifo_regif
  import uart_fr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  addr,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  input  logic        rx_push,
  input  logic [7:0]  rx_byte,
  input  logic        rx_err,
  input  logic        tx_pop,
  output logic [7:0]  tx_byte,
  output logic        tx_has_data,
  output logic        rx_ready,
  output logic        tx_ready,
  output logic        irq,
  output logic        fifos_on,
  output logic [6:0]  line_ctrl,
  output logic [15:0] divisor,
  output logic [7:0]  alt_func
);
  fcr_t          fcr;
  logic          rx_flush, tx_flush, dlab, fcr_wr, host_push, host_pop, lsr_rd;
  logic [8:0]    rx_head;
  logic [7:0]    tx_head;
  logic [CW-1:0] rx_count, tx_count, err_cnt, err_cnt_nx, trig_lvl;
  logic          rx_full, tx_full, rx_push_ok, rx_pop_ok, tx_pop_ok, unused_tx_push_ok;
  logic          rx_empty, tx_empty, rx_avail, mode1, overrun, overrun_nx;
  logic [7:0]    lcr, lcr_nx, dll, dll_nx, dlm, dlm_nx, afr, afr_nx, rx_last, rx_last_nx;
  logic [7:0]    tx_last, tx_last_nx, iir, lsr;
  logic [3:0]    ier, ier_nx, iir_id;

  assign dlab      = lcr[7];
  assign fcr_wr    = wr_en & (addr == A_IDFC) & ~dlab;
  assign host_push = wr_en & (addr == A_DATA) & ~dlab;
  assign host_pop  = rd_en & (addr == A_DATA) & ~dlab;
  assign lsr_rd    = rd_en & (addr == A_LSR);

  urt_fcr_ctl u_fcr (
    .clk(clk), .rst_n(rst_n), .fcr_wr(fcr_wr), .wdata(wdata),
    .fcr(fcr), .rx_flush(rx_flush), .tx_flush(tx_flush)
  );

  urt_byte_fifo #(.W(9), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush), .single(~fcr.on),
    .push(rx_push), .push_data({rx_err, rx_byte}), .pop(host_pop),
    .head(rx_head), .count(rx_count), .full(rx_full),
    .push_ok(rx_push_ok), .pop_ok(rx_pop_ok)
  );

  urt_byte_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush), .single(~fcr.on),
    .push(host_push), .push_data(wdata), .pop(tx_pop),
    .head(tx_head), .count(tx_count), .full(tx_full),
    .push_ok(unused_tx_push_ok), .pop_ok(tx_pop_ok)
  );

  assign rx_empty = (rx_count == '0);
  assign tx_empty = (tx_count == '0);

  always_comb begin
    case (fcr.trig)
      2'd0:    trig_lvl = CW'(1);
      2'd1:    trig_lvl = CW'(DEPTH / 4);
      2'd2:    trig_lvl = CW'(DEPTH / 2);
      default: trig_lvl = CW'(DEPTH - 2);
    endcase
  end

  assign rx_avail = fcr.on ? (rx_count >= trig_lvl) : ~rx_empty;
  assign mode1    = fcr.on & fcr.dma;
  assign rx_ready = mode1 ? rx_avail : ~rx_empty;
  assign tx_ready = mode1 ? ~tx_full : tx_empty;

  assign iir_id = (ier[0] & rx_avail) ? 4'b0100 :
                  (ier[1] & tx_empty) ? 4'b0010 : 4'b0001;
  assign iir    = {fcr.on, fcr.on, 2'b00, iir_id};
  assign lsr    = {fcr.on & (err_cnt != '0), 1'b0, tx_empty, 3'b000, overrun, ~rx_empty};
  assign irq    = ~iir_id[0];

  always_comb begin
    case (addr)
      A_DATA:  rdata = dlab ? dll : (rx_empty ? rx_last : rx_head[7:0]);
      A_IER:   rdata = dlab ? dlm : {4'b0000, ier};
      A_IDFC:  rdata = dlab ? afr : iir;
      A_LCR:   rdata = lcr;
      A_LSR:   rdata = lsr;
      default: rdata = 8'h00;
    endcase
  end

  assign tx_byte     = tx_empty ? tx_last : tx_head;
  assign tx_has_data = ~tx_empty;
  assign fifos_on    = fcr.on;
  assign line_ctrl   = lcr[6:0];
  assign divisor     = {dlm, dll};
  assign alt_func    = afr;

  always_comb begin
    lcr_nx     = lcr;
    dll_nx     = dll;
    dlm_nx     = dlm;
    afr_nx     = afr;
    ier_nx     = ier;
    rx_last_nx = rx_pop_ok ? rx_head[7:0] : rx_last;
    tx_last_nx = tx_pop_ok ? tx_head : tx_last;
    if (wr_en) begin
      if (addr == A_LCR)                 lcr_nx = wdata;
      if (addr == A_DATA && dlab)        dll_nx = wdata;
      if (addr == A_IER && dlab)         dlm_nx = wdata;
      if (addr == A_IER && !dlab)        ier_nx = wdata[3:0];
      if (addr == A_IDFC && dlab)        afr_nx = wdata;
    end
    if (rx_flush) err_cnt_nx = '0;
    else err_cnt_nx = err_cnt + CW'(rx_push_ok & rx_err) - CW'(rx_pop_ok & rx_head[8]);
    if (rx_push & rx_full & ~rx_flush) overrun_nx = 1'b1;
    else if (lsr_rd)                   overrun_nx = 1'b0;
    else                               overrun_nx = overrun;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr     <= '0;
      dll     <= '0;
      dlm     <= '0;
      afr     <= '0;
      ier     <= '0;
      rx_last <= '0;
      tx_last <= '0;
      err_cnt <= '0;
      overrun <= 1'b0;
    end else begin
      lcr     <= lcr_nx;
      dll     <= dll_nx;
      dlm     <= dlm_nx;
      afr     <= afr_nx;
      ier     <= ier_nx;
      rx_last <= rx_last_nx;
      tx_last <= tx_last_nx;
      err_cnt <= err_cnt_nx;
      overrun <= overrun_nx;
    end
  end

endmodule

// File: rtl/uart_fifo_regif_chk.sv
module uart_fifo_regif_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    addr,
  input logic          wr_en,
  input logic [7:0]    wdata,
  input logic [7:0]    rdata,
  input logic          dlab,
  input logic          fifos_on,
  input logic          dma,
  input logic [1:0]    trig,
  input logic [CW-1:0] rx_count,
  input logic [CW-1:0] tx_count,
  input logic          rx_full,
  input logic          rx_push,
  input logic          overrun,
  input logic          rx_ready
);
  logic ctl_wr;
  assign ctl_wr = wr_en && addr == 3'd2 && !dlab;

  // R7
  rx_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= (fifos_on ? CW'(DEPTH) : CW'(1)));

  // R7
  tx_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count <= (fifos_on ? CW'(DEPTH) : CW'(1)));

  // R5
  toggle_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && wdata[0] != fifos_on) |=> (rx_count == '0 && tx_count == '0));

  // R6
  rx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && wdata[0] && wdata[1]) |=> rx_count == '0);

  // R6
  tx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && wdata[0] && wdata[2]) |=> tx_count == '0);

  // R4
  gated_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !wdata[0]) |=> $stable({trig, dma}));

  // R7
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_full && !ctl_wr) |=> overrun);

  // R10
  mode0_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifos_on && dma) |-> (rx_ready == (rx_count != '0)));

  // R2
  iir_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 3'd2 && !dlab) |-> (rdata[7:6] == {fifos_on, fifos_on}));

endmodule

bind uart_fifo_regif uart_fifo_regif_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .rdata(rdata), .dlab(dlab), .fifos_on(fifos_on), .dma(fcr.dma),
  .trig(fcr.trig), .rx_count(rx_count), .tx_count(tx_count),
  .rx_full(rx_full), .rx_push(rx_push), .overrun(overrun), .rx_ready(rx_ready)
);

// File: tb/uart_fifo_regif_test.sv
module uart_fifo_regif_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0, rx_push = 1'b0, rx_err = 1'b0, tx_pop = 1'b0;
  logic [7:0] wdata = '0, rx_byte = '0;
  logic [7:0] rdata, tx_byte, alt_func;
  logic tx_has_data, rx_ready, tx_ready, irq, fifos_on;
  logic [6:0] line_ctrl;
  logic [15:0] divisor;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_fifo_regif uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .rx_push(rx_push), .rx_byte(rx_byte),
    .rx_err(rx_err), .tx_pop(tx_pop), .tx_byte(tx_byte), .tx_has_data(tx_has_data),
    .rx_ready(rx_ready), .tx_ready(tx_ready), .irq(irq), .fifos_on(fifos_on),
    .line_ctrl(line_ctrl), .divisor(divisor), .alt_func(alt_func)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic host_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic rxp(input logic [7:0] d, input logic e);
    @(negedge clk); rx_push = 1'b1; rx_byte = d; rx_err = e;
    @(negedge clk); rx_push = 1'b0; rx_err = 1'b0;
  endtask

  task automatic txp(output logic [7:0] d);
    @(negedge clk); tx_pop = 1'b1; #1 d = tx_byte;
    @(negedge clk); tx_pop = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    peek(3'd3, v); chk("R1 lcr", v, 8'h00);
    peek(3'd2, v); chk("R1 iir", v, 8'h01);
    peek(3'd5, v); chk("R1 lsr", v, 8'h20);
    chk("R1 ready", {fifos_on, rx_ready, tx_ready}, 3'b001);
    chk("R1 divisor", divisor, 16'h0000);

    // R3 bank mapping
    host_wr(3'd3, 8'h80);
    host_wr(3'd0, 8'h34); host_wr(3'd1, 8'h12); host_wr(3'd2, 8'h5A);
    peek(3'd0, v); chk("R3 dll", v, 8'h34);
    peek(3'd1, v); chk("R3 dlm", v, 8'h12);
    peek(3'd2, v); chk("R3 afr", v, 8'h5A);
    chk("R3 outs", {divisor, alt_func}, 24'h12345A);
    chk("R3 no fifo write", fifos_on, 1'b0);
    host_wr(3'd3, 8'h03);
    host_wr(3'd1, 8'h01);
    peek(3'd1, v); chk("R3 ier", v, 8'h01);
    chk("R3 line", line_ctrl, 7'h03);
    peek(3'd2, v); chk("R2 iir idle", v, 8'h01);

    // R7 / R8 single-entry mode
    rxp(8'hA5, 1'b0); rxp(8'h3C, 1'b0);
    peek(3'd5, v); chk("R7 overrun lsr", v, 8'h23);
    chk("R2 irq", irq, 1'b1);
    host_rd(3'd5, v);
    peek(3'd5, v); chk("R7 overrun clear", v, 8'h21);
    host_rd(3'd0, v); chk("R7 single byte", v, 8'hA5);
    host_rd(3'd0, v); chk("R8 empty rx pop", v, 8'hA5);
    peek(3'd5, v); chk("R8 count stays 0", v, 8'h20);
    host_wr(3'd0, 8'h11); host_wr(3'd0, 8'h22);
    txp(v); chk("R7 tx single", v, 8'h11);
    txp(v); chk("R8 empty tx pop", v, 8'h11);
    chk("R8 tx empty", tx_has_data, 1'b0);

    // R4 write with enable clear is ignored
    rxp(8'h77, 1'b0); host_wr(3'd0, 8'h66);
    host_wr(3'd2, 8'hCE);
    peek(3'd5, v); chk("R4 no flush lsr", v, 8'h01);
    chk("R4 tx kept", {tx_has_data, fifos_on}, 2'b10);
    peek(3'd2, v); chk("R4 iir", v, 8'h04);

    // R5 enabling flushes both
    host_wr(3'd2, 8'h01);
    peek(3'd5, v); chk("R5 flush on enable", v, 8'h20);
    peek(3'd2, v); chk("R2 iir on", v, 8'hC1);

    // R7 deep fifo, order and overrun
    for (int i = 0; i < 17; i++) rxp(8'h40 + 8'(i), 1'b0);
    peek(3'd5, v); chk("R7 fifo overrun", v, 8'h23);
    for (int i = 0; i < 16; i++) begin
      host_rd(3'd0, v); chk("R7 order", v, 8'h40 + 8'(i));
    end
    host_rd(3'd5, v);
    peek(3'd5, v); chk("R7 drained", v, 8'h20);

    // R11 error summary
    rxp(8'h10, 1'b0); rxp(8'h20, 1'b1);
    peek(3'd5, v); chk("R11 err held", v, 8'hA1);
    host_rd(3'd0, v); chk("R11 byte", v, 8'h10);
    peek(3'd5, v); chk("R11 err still", v, 8'hA1);
    host_rd(3'd0, v); chk("R11 err byte", v, 8'h20);
    peek(3'd5, v); chk("R11 err gone", v, 8'h20);

    // R6 individual flushes
    for (int i = 0; i < 3; i++) begin rxp(8'(i), 1'b0); host_wr(3'd0, 8'(i)); end
    host_wr(3'd2, 8'h03);
    peek(3'd5, v); chk("R6 rx flush only", v, 8'h00);
    rxp(8'h55, 1'b0);
    host_wr(3'd2, 8'h05);
    peek(3'd5, v); chk("R6 tx flush only", v, 8'h21);
    host_rd(3'd0, v); chk("R6 rx kept", v, 8'h55);

    // R10 ready signalling
    chk("R10 mode0 tx empty", tx_ready, 1'b1);
    host_wr(3'd0, 8'h99);
    chk("R10 mode0 tx busy", tx_ready, 1'b0);
    host_wr(3'd2, 8'h0D);
    chk("R10 mode1 tx", tx_ready, 1'b1);
    for (int i = 0; i < 16; i++) begin
      host_wr(3'd0, 8'(i));
      chk("R10 mode1 tx fill", tx_ready, (i < 15) ? 1'b1 : 1'b0);
    end
    txp(v); chk("R10 tx head", v, 8'h00);
    chk("R10 mode1 tx space", tx_ready, 1'b1);

    // R9 trigger sweep
    for (int code = 0; code < 4; code++) begin
      int lvl;
      lvl = (code == 0) ? 1 : (code == 1) ? 4 : (code == 2) ? 8 : 14;
      host_wr(3'd2, 8'(code << 6) | 8'h0B);
      for (int n = 0; n <= 16; n++) begin
        if (n > 0) rxp(8'(n), 1'b0);
        peek(3'd2, v);
        chk("R9 iir level", v, (n >= lvl) ? 8'hC4 : 8'hC1);
        chk("R10 rx ready mode1", rx_ready, (n >= lvl) ? 1'b1 : 1'b0);
      end
    end

    // R10 mode0 rx ready with fifos on and high trigger
    host_wr(3'd2, 8'hC3);
    chk("R10 mode0 rx empty", rx_ready, 1'b0);
    rxp(8'h01, 1'b0);
    chk("R10 mode0 rx one", rx_ready, 1'b1);

    // R5 disabling flushes both
    host_wr(3'd0, 8'hEE);
    host_wr(3'd2, 8'h00);
    peek(3'd5, v); chk("R5 flush on disable", v, 8'h20);
    chk("R5 state", {fifos_on, tx_has_data}, 2'b00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule